// File: doc/BRIEF.md
# APB Dual Down-Counter Timer

This block is an APB slave holding two identical timers that count down independently. Each timer has a period register and a live count register. A per-timer prescaler divides the APB clock by 1, 16 or 256 to produce count ticks. The counter can be 16 or 32 bits wide. When the count reaches zero, the timer raises a raw interrupt flag. On the tick after zero, the counter does one of three things, depending on its mode:

- wraps to all-ones (free-running mode),
- reloads from the period register (periodic mode),
- stays at zero (one-shot mode).

Software programs a timer as follows:

- A write to the period register sets both the period and the live count.
- A write to the background period register changes only the value used at the next reload.
- A control write enables the timer and selects its mode.
- Any write to the clear register drops the flag.

Each timer drives its own interrupt pin, which is its flag masked by its interrupt enable. A combined pin is the OR of the two. Both timers run on the APB clock.

Top module: `apb_dual_timer`

## Requirements
- R1: Word registers per timer: 0x00 period (read returns the stored period), 0x04 live count (read only), 0x08 control, 0x0C flag clear (write only, reads 0), 0x10 raw flag in bit 0, 0x14 masked flag in bit 0, 0x18 background period. After reset every register reads 0.
- R2: Control bit 7 enables counting. While the timer is disabled, the live count changes only on a period write. Writing 0 to control stops the count.
- R3: Control bits [3:2] select the tick divider: 00 gives 1, 01 gives 16, 10 and 11 give 256. A period write restarts the divider, so the first tick falls exactly one divider period later.
- R4: On each tick, a nonzero count decrements by one, so N ticks after a period write of L the count reads L-N.
- R5: The raw flag becomes 1 on the tick that takes the count from 1 to 0. A reload does not set it.
- R6: Free-running mode (bits 6 and 0 clear): the tick at zero sets the count to all-ones of the active width (0xFFFF in 16-bit mode).
- R7: Periodic mode (bit 6 set, bit 0 clear): the tick at zero reloads the count from the stored period.
- R8: One-shot mode (bit 0 set, which takes priority over bit 6): the count stays at zero until the next period write.
- R9: Any write to the clear register clears the raw flag, whatever the data. A zero event in the same cycle wins.
- R10: Masked flag = raw flag AND control bit 5. timer_irq[n] equals timer n's masked flag, and irq_any is the OR of both.
- R11: A background period write changes the stored period but not the live count. A period write sets both.
- R12: With control bit 1 clear, the counter is 16 bits: only the low 16 bits count, and the upper bits of the live count read 0. With bit 1 set, all 32 bits count.
- R13: The second timer uses the same layout at 0x20. Accesses to one timer never affect the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock, also the timer clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address, word aligned |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid while selected for read |
| timer_irq | output | 2 | Per-timer masked interrupt |
| irq_any | output | 1 | OR of both timer interrupts |

## Verification
The embedded properties check several rules on every cycle:

- a tick on a count above one decrements it by exactly one,
- the 1-to-0 tick raises the flag,
- a clear with no coincident zero event drops it,
- a one-shot count at zero stays there,
- a disabled count stays frozen,
- a background period write leaves the count alone,
- free-running mode wraps to all-ones,
- the divider never issues back-to-back ticks when dividing.

Only the bench scenarios can show the following:

- the exact tick count a divider setting produces over a long interval,
- the periodic reload value picked up from a background write,
- register readback and address layout,
- 16-bit truncation of a 32-bit load,
- isolation between the two timers,
- the combined interrupt pin.

// File: rtl/dtim_pkg.sv
`timescale 1ns/1ps
package dtim_pkg;

    // control field layout (bit positions are software visible)
    typedef struct packed {
        logic       en;        // bit 7
        logic       periodic;  // bit 6
        logic       inten;     // bit 5
        logic [1:0] pre;       // bits 3:2
        logic       wide;      // bit 1
        logic       oneshot;   // bit 0
    } dtim_ctrl_t;

    typedef enum logic [2:0] {
        REG_PERIOD = 3'd0,
        REG_COUNT  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_CLEAR  = 3'd3,
        REG_RAW    = 3'd4,
        REG_MASKED = 3'd5,
        REG_BGPER  = 3'd6,
        REG_SPARE  = 3'd7
    } dtim_reg_e;

    localparam int NARROW_W = 16;

endpackage

// File: rtl/dtim_prescaler.sv
`timescale 1ns/1ps
module dtim_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int HALF_W = PRE_W / 2;
    localparam logic [PRE_W-1:0] LAST_MID  = {{(PRE_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [PRE_W-1:0] LAST_FULL = {PRE_W{1'b1}};
    localparam logic [PRE_W-1:0] STEP      = {{(PRE_W-1){1'b0}}, 1'b1};

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        unique case (sel)
            2'b00:   last = '0;
            2'b01:   last = LAST_MID;
            default: last = LAST_FULL;
        endcase
        tick  = run && (cnt_q == last);
        cnt_d = cnt_q + STEP;
        if (!run || restart || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 2'b00) |=> (!tick || sel == 2'b00)); // R3

endmodule

// File: rtl/dtim_channel.sv
`timescale 1ns/1ps
module dtim_channel
    import dtim_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       reg_sel,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    localparam logic [CNT_W-1:0] MASK_NARROW = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [CNT_W-1:0] ONE         = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        dtim_ctrl_t       ctrl;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] value;
        logic             ris;
    } ch_state_t;

    ch_state_t        st_d, st_q;
    dtim_reg_e        rsel;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] active;
    logic             wr_period, wr_ctrl, wr_clear, wr_bg;
    logic             tick, reach_zero, mis;

    always_comb begin
        rsel      = dtim_reg_e'(reg_sel);
        wr_period = wr_en && (rsel == REG_PERIOD);
        wr_ctrl   = wr_en && (rsel == REG_CTRL);
        wr_clear  = wr_en && (rsel == REG_CLEAR);
        wr_bg     = wr_en && (rsel == REG_BGPER);
        mask      = st_q.ctrl.wide ? {CNT_W{1'b1}} : MASK_NARROW;
        active    = st_q.value & mask;
        mis       = st_q.ris & st_q.ctrl.inten;
    end

    dtim_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.ctrl.en),
        .restart (wr_period),
        .sel     (st_q.ctrl.pre),
        .tick    (tick)
    );

    always_comb begin
        st_d       = st_q;
        reach_zero = 1'b0;
        if (tick) begin
            if (active == '0) begin
                if (st_q.ctrl.oneshot)       st_d.value = '0;
                else if (st_q.ctrl.periodic) st_d.value = st_q.period & mask;
                else                         st_d.value = mask;
            end else begin
                st_d.value = active - ONE;
                reach_zero = (active == ONE);
            end
        end
        if (wr_clear)   st_d.ris = 1'b0;
        if (reach_zero) st_d.ris = 1'b1;
        if (wr_ctrl) begin
            st_d.ctrl.en       = wdata[7];
            st_d.ctrl.periodic = wdata[6];
            st_d.ctrl.inten    = wdata[5];
            st_d.ctrl.pre      = wdata[3:2];
            st_d.ctrl.wide     = wdata[1];
            st_d.ctrl.oneshot  = wdata[0];
        end
        if (wr_bg) st_d.period = wdata;
        if (wr_period) begin
            st_d.period = wdata;
            st_d.value  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        unique case (rsel)
            REG_PERIOD: rdata = st_q.period;
            REG_COUNT:  rdata = active;
            REG_CTRL:   rdata[7:0] = {st_q.ctrl.en, st_q.ctrl.periodic, st_q.ctrl.inten,
                                      1'b0, st_q.ctrl.pre, st_q.ctrl.wide, st_q.ctrl.oneshot};
            REG_RAW:    rdata[0] = st_q.ris;
            REG_MASKED: rdata[0] = mis;
            REG_BGPER:  rdata = st_q.period;
            default:    rdata = '0;
        endcase
        irq = mis;
    end

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && active > ONE && !wr_period && !wr_ctrl) |=> (active == $past(active) - ONE)); // R4
    AST_FLAG_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && active == ONE) |=> st_q.ris); // R5
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && active == '0 && !st_q.ctrl.oneshot && !st_q.ctrl.periodic && !wr_period && !wr_ctrl)
        |=> (&active[NARROW_W-1:0])); // R6
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.oneshot && active == '0 && !wr_period && !wr_ctrl) |=> (active == '0)); // R8
    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && !(tick && active == ONE)) |=> !st_q.ris); // R9
    AST_BG_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bg && !tick && !wr_ctrl) |=> $stable(active)); // R11
    AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !wr_period) |=> $stable(st_q.value)); // R2

endmodule

// File: rtl/apb_dual_timer.sv
`timescale 1ns/1ps
module apb_dual_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic [1:0]        timer_irq,
    output logic              irq_any
);
    localparam int NUM_TMR  = 2;
    localparam int SLOT_BIT = 5;   // 0x20 stride between timers
    localparam int WORD_LSB = 2;

    logic                           acc_wr, in_range;
    logic [NUM_TMR-1:0][DATA_W-1:0] ch_rdata;
    logic [NUM_TMR-1:0]             ch_irq;

    always_comb begin
        in_range = (paddr[ADDR_W-1:SLOT_BIT+1] == '0) && (paddr[WORD_LSB-1:0] == '0);
        acc_wr   = psel && penable && pwrite && in_range;
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        logic slot_hit;
        assign slot_hit = (paddr[SLOT_BIT] == g[0]);
        dtim_channel #(.CNT_W(DATA_W), .PRE_W(PRE_W)) u_ch (
            .clk     (pclk),
            .rst_n   (presetn),
            .wr_en   (acc_wr && slot_hit),
            .reg_sel (paddr[SLOT_BIT-1:WORD_LSB]),
            .wdata   (pwdata),
            .rdata   (ch_rdata[g]),
            .irq     (ch_irq[g])
        );
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite && in_range) prdata = ch_rdata[paddr[SLOT_BIT]];
        timer_irq = ch_irq;
        irq_any   = |ch_irq;
    end

endmodule

// File: tb/tb_apb_dual_timer.sv
`timescale 1ns/1ps
module tb_apb_dual_timer;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [1:0]  timer_irq;
    logic        irq_any;

    int cyc = 0;
    int vectors = 0;
    int fails = 0;
    int e0 [2];

    localparam logic [7:0] O_PER = 8'h00, O_CNT = 8'h04, O_CTL = 8'h08, O_CLR = 8'h0C,
                           O_RAW = 8'h10, O_MSK = 8'h14, O_BG = 8'h18;

    apb_dual_timer dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .timer_irq(timer_irq), .irq_any(irq_any)
    );

    always #2.5 pclk = ~pclk;
    always @(posedge pclk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int t, input logic [7:0] a, input logic [31:0] d);
        @(posedge pclk); #1;
        psel = 1; pwrite = 1; paddr = a + 8'(t * 32); pwdata = d; penable = 0;
        @(posedge pclk); #1; penable = 1;
        @(posedge pclk); #1; psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input int t, input logic [7:0] a, output logic [31:0] d,
                      output int at, output logic [1:0] irqs);
        @(posedge pclk); #1;
        psel = 1; pwrite = 0; paddr = a + 8'(t * 32); penable = 0;
        @(posedge pclk); #1; penable = 1;
        #1; d = prdata; at = cyc; irqs = timer_irq;
        @(posedge pclk); #1; psel = 0; penable = 0;
    endtask

    // returns {raw flag, count} after k clock edges from a period write / enable
    function automatic logic [32:0] model(logic [31:0] ld, logic [31:0] per, int k, logic [7:0] c);
        logic [31:0] m, v;
        logic r;
        int d;
        m = c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        v = ld & m;
        r = 1'b0;
        d = (c[3:2] == 2'b00) ? 1 : (c[3:2] == 2'b01) ? 16 : 256;
        if (c[7]) begin
            for (int t = 0; t < k / d; t++) begin
                if (v == 0) begin
                    if (c[0])      v = 0;
                    else if (c[6]) v = per & m;
                    else           v = m;
                end else begin
                    v = v - 1;
                    if (v == 0) r = 1'b1;
                end
            end
        end
        return {r, v};
    endfunction

    // run one timer from a fresh load and compare count, flag and pin against the model
    task automatic run_and_check(input string tag, input int t, input logic [31:0] ld,
                                 input logic [31:0] bg, input logic [7:0] c, input int waitn);
        logic [31:0] d;
        logic [1:0]  ir;
        int          at;
        logic [32:0] e;
        wr(t, O_CTL, 32'h0);
        wr(t, O_CLR, 32'h0);
        wr(t, O_PER, ld);
        if (bg != ld) wr(t, O_BG, bg);
        wr(t, O_CTL, {24'h0, c});
        e0[t] = cyc;
        repeat (waitn) @(posedge pclk);
        rd(t, O_CNT, d, at, ir);
        e = model(ld, bg, at - e0[t], c);
        chk({tag, " count"}, d, e[31:0]);
        rd(t, O_RAW, d, at, ir);
        e = model(ld, bg, at - e0[t], c);
        chk({tag, " raw flag R5"}, d, {31'h0, e[32]});
        chk({tag, " irq pin R10"}, {31'h0, ir[t]}, {31'h0, e[32] & c[5]});
    endtask

    initial begin
        repeat (190000) @(posedge pclk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        logic [1:0]  ir;
        int          at;
        logic [32:0] e;
        void'($urandom(32'd24681));
        repeat (4) @(posedge pclk);
        #1 presetn = 1'b1;

        // R1 reset state
        rd(0, O_RAW, d, at, ir); chk("R1 reset raw", d, 0);
        rd(0, O_CNT, d, at, ir); chk("R1 reset count", d, 0);
        rd(1, O_CTL, d, at, ir); chk("R1 reset ctrl", d, 0);
        chk("R10 reset pins", {29'h0, irq_any, timer_irq}, 0);

        // R1 readback of period and control, clear reads 0
        wr(0, O_PER, 32'h0000_0ABC); rd(0, O_PER, d, at, ir); chk("R1 period readback", d, 32'hABC);
        wr(0, O_CTL, 32'hFFFF_FF6F); rd(0, O_CTL, d, at, ir); chk("R1 ctrl readback", d, 32'h6F);
        rd(0, O_CLR, d, at, ir); chk("R1 clear reads zero", d, 0);
        wr(0, O_CTL, 32'h0);

        // R4 R5 R6 free-running 16-bit, divide 1, across zero
        run_and_check("R4 free 16b mid", 0, 1000, 1000, 8'hA0, 495);
        run_and_check("R6 free 16b wrap", 0, 1000, 1000, 8'hA0, 1003);
        // R7 periodic divide-by-16 past zero
        run_and_check("R7 periodic div16", 1, 20, 20, 8'hE4, 20 * 16 + 30);
        // R9 clear with arbitrary data
        wr(1, O_CLR, 32'hDEAD_BEEF);
        rd(1, O_RAW, d, at, ir); chk("R9 raw after clear", d, 0);
        chk("R9 pin after clear", {31'h0, ir[1]}, 0);

        // R8 one-shot holds at zero, then a new period write restarts it
        run_and_check("R8 oneshot", 0, 5, 5, 8'hA1, 40);
        repeat (30) @(posedge pclk);
        rd(0, O_CNT, d, at, ir); chk("R8 oneshot still zero", d, 0);
        wr(0, O_CLR, 32'h1);
        wr(0, O_PER, 32'd7);
        e0[0] = cyc;
        repeat (3) @(posedge pclk);
        rd(0, O_CNT, d, at, ir);
        e = model(7, 7, at - e0[0], 8'hA1);
        chk("R8 oneshot reload", d, e[31:0]);

        // R11 background write does not touch the count, reload uses it
        wr(0, O_CTL, 32'h0); wr(0, O_CLR, 0); wr(0, O_PER, 32'd30); wr(0, O_BG, 32'd100);
        rd(0, O_CNT, d, at, ir); chk("R11 count unchanged by bg", d, 30);
        rd(0, O_PER, d, at, ir); chk("R11 period from bg", d, 100);
        wr(0, O_CTL, 32'hC0);
        e0[0] = cyc;
        repeat (60) @(posedge pclk);
        rd(0, O_CNT, d, at, ir);
        e = model(30, 100, at - e0[0], 8'hC0);
        chk("R11 R7 reload from bg", d, e[31:0]);
        rd(0, O_MSK, d, at, ir); chk("R10 masked with enable clear", d, 0);
        chk("R10 pin with enable clear", {31'h0, ir[0]}, 0);
        rd(0, O_RAW, d, at, ir); chk("R10 raw still set", d, 1);

        // R2 stop by writing 0
        wr(0, O_CTL, 32'h0);
        rd(0, O_CNT, d, at, ir);
        repeat (50) @(posedge pclk);
        rd(0, O_CNT, d2, at, ir); chk("R2 stopped count frozen", d2, d);

        // R12 16-bit truncation and 32-bit view
        wr(0, O_PER, 32'h1234_5678);
        rd(0, O_CNT, d, at, ir); chk("R12 narrow view", d, 32'h5678);
        wr(0, O_CTL, 32'h02);
        rd(0, O_CNT, d, at, ir); chk("R12 wide view", d, 32'h1234_5678);
        run_and_check("R12 wide free wrap", 0, 3, 3, 8'h82, 6);

        // R3 encoding 11 divides by 256, and a period write restarts the divider
        run_and_check("R3 div 11", 1, 4, 4, 8'h8C, 600);
        wr(1, O_CTL, 32'h0); wr(1, O_CLR, 0); wr(1, O_PER, 32'd50); wr(1, O_CTL, 32'h86);
        repeat (7) @(posedge pclk);
        wr(1, O_PER, 32'd9);
        e0[1] = cyc;
        repeat (40) @(posedge pclk);
        rd(1, O_CNT, d, at, ir);
        e = model(9, 9, at - e0[1], 8'h86);
        chk("R3 divider restart on period write", d, e[31:0]);

        // R13 independence: timer 0 frozen while timer 1 counts
        wr(0, O_CTL, 32'h0); wr(0, O_PER, 32'd77);
        run_and_check("R13 timer1 runs", 1, 200, 200, 8'h80, 100);
        rd(0, O_CNT, d, at, ir); chk("R13 timer0 untouched", d, 77);

        // R10 combined pin
        wr(0, O_CLR, 0); wr(1, O_CLR, 0);
        wr(0, O_PER, 3); wr(0, O_CTL, 32'hA1);
        wr(1, O_PER, 3); wr(1, O_CTL, 32'hA1);
        repeat (20) @(posedge pclk); #1;
        chk("R10 both pins", {30'h0, timer_irq}, 3);
        chk("R10 any pin", {31'h0, irq_any}, 1);
        wr(0, O_CLR, 0); #1;
        chk("R10 any after one clear", {31'h0, irq_any}, 1);
        wr(1, O_CLR, 0); #1;
        chk("R10 any after both clear", {31'h0, irq_any}, 0);

        // constrained random trials (R4 R5 R6 R7 R8 R12)
        for (int i = 0; i < 30; i++) begin
            int          t, dv, w;
            logic [7:0]  c;
            logic [31:0] ld, bg;
            t  = $urandom_range(0, 1);
            c  = 8'($urandom) & 8'h6F;
            c[7] = 1'b1;
            dv = (c[3:2] == 2'b00) ? 1 : (c[3:2] == 2'b01) ? 16 : 256;
            ld = (dv == 256) ? $urandom_range(0, 12) : $urandom_range(0, 60);
            bg = ($urandom_range(0, 1) == 1) ? ld : $urandom_range(0, 40);
            w  = $urandom_range(0, (ld + 4) * dv);
            run_and_check("R4 random", t, ld, bg, c, w);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule